// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front-End

This block is the clocked control and burst-address front-end of a pipelined burst static RAM. It samples its inputs on each rising clock edge. These inputs are two active-low address strobes (one meant for a processor, one for a cache controller), three chip enables of mixed polarity, a global write enable, per-byte write enables, an active-low burst-advance input and a static burst-order select. From them it decides whether to start a new access, step an ongoing four-beat burst, hold, or deselect.

Its outputs drive a storage array. These are a registered array address, read and write strobes, a per-byte write mask, registered write data, and a two-stage registered read-data path with a valid flag. The storage array itself sits outside the block. The strobes differ in two ways. The processor strobe always reads and is gated by the primary enable. The controller strobe can read or write, and it deselects the device when the primary enable is inactive.

Top module: `sync_burst_front`

## Requirements
- R1: When `procStrobeN` is low, `enPrimN` low, `enSecond` high and `enThirdN` low at an edge, `addrIn` is loaded and a read is issued: after that edge `memRd` is 1 and `memAddr` equals the sampled `addrIn`.
- R2: A cycle taken by the processor strobe never writes, whatever `wrEnN`, `byteWrN` or `ctrlStrobeN` hold: `memWr` is 0 after that edge.
- R3: While `enPrimN` is high, `procStrobeN` has no effect. The cycle follows the controller-strobe, advance and hold rules as if `procStrobeN` were high, so an ongoing burst keeps advancing.
- R4: A processor strobe with `enPrimN` low but `enSecond` low or `enThirdN` high deselects the device. It makes no access, and later advance cycles make none until a new load.
- R5: When `ctrlStrobeN` is low, the processor strobe is not in effect and all three enables are active, `addrIn` is loaded and any burst is aborted. The access is a write if `wrEnN` is 0 and a read if it is 1.
- R6: A controller strobe with any enable inactive deselects the device, which then makes no access.
- R7: With `orderSel` = 0 (linear), the address of beat i (i = 0..3, beat 0 = load) is the loaded address with its two low bits replaced by (start + i) mod 4. The upper bits are held.
- R8: With `orderSel` = 1 (interleaved), the two low bits of beat i are start XOR i.
- R9: With no strobe in effect, the device selected and `advN` low, the beat counter steps by one. The access uses the new burst address and is a write when `wrEnN` is 0, else a read.
- R10: With no strobe in effect and `advN` high, no access is made, the beat counter holds and `memAddr` stays unchanged.
- R11: On a write, `memByteMask` bit j is 1 exactly when `byteWrN` bit j was 0 (lane j = data bits 8j+7..8j), and `memWrData` carries the `wrData` sampled at the same edge. On any non-write cycle `memByteMask` is 0.
- R12: Data for a read registered at edge k shows on `rdData` with `rdValid` = 1 after edge k+2. `rdValid` is 0 two edges after a cycle with no read, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| procStrobeN | input | 1 | Processor address strobe, active low |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| enPrimN | input | 1 | Primary chip enable, active low |
| enSecond | input | 1 | Second chip enable, active high |
| enThirdN | input | 1 | Third chip enable, active low |
| wrEnN | input | 1 | Global write enable, active low |
| byteWrN | input | LANES | Per-lane write enables, active low |
| advN | input | 1 | Burst advance, active low |
| orderSel | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addrIn | input | ADDR_W | External address |
| wrData | input | LANES*LANE_W | Write data |
| memRdData | input | LANES*LANE_W | Read data returned by the array for `memAddr` |
| memAddr | output | ADDR_W | Registered array address |
| memRd | output | 1 | Registered read strobe |
| memWr | output | 1 | Registered write strobe |
| memByteMask | output | LANES | Registered per-lane write mask |
| memWrData | output | LANES*LANE_W | Registered write data |
| rdData | output | LANES*LANE_W | Pipelined read data |
| rdValid | output | 1 | Read data valid |

## Verification
Two functions can collide in one cycle: a new load from a strobe, and the burst advance of a burst already running. Some bursts are therefore broken off with a controller strobe, or with a processor strobe that arrives while the primary enable is high, with `advN` held low in the same cycle. The bench judges the collision by the array address issued after that edge. An effective strobe must win with the new address. An ignored processor strobe must give the next burst address. The bursts sweep every starting offset in both orders. Where a write and a processor strobe coincide, the bench checks that no write strobe is issued.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  // Strobes handed from the control decoder to the datapath for one cycle.
  typedef struct packed {
    logic load;  // register a new external address, beat = 0
    logic adv;   // step the beat counter
    logic rd;    // issue an array read this cycle
    logic wr;    // issue an array write this cycle
  } sbfStrobe_t;

  localparam int BEAT_W = 2;  // four-beat bursts

  function automatic logic [BEAT_W-1:0] burstLow(input logic [BEAT_W-1:0] start,
                                                 input logic [BEAT_W-1:0] beat,
                                                 input logic interleave);
    logic [BEAT_W-1:0] sum;
    sum = start + beat;
    return interleave ? (start ^ beat) : sum;
  endfunction

endpackage

// File: rtl/sbf_ctrl.sv
module sbf_ctrl
  import sbf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       procStrobeN,
  input  logic       ctrlStrobeN,
  input  logic       enPrimN,
  input  logic       enSecond,
  input  logic       enThirdN,
  input  logic       wrEnN,
  input  logic       advN,
  output sbfStrobe_t strobe
);

  logic enablesOk;
  logic procTaken;
  logic ctrlTaken;
  logic deselect;
  logic selected;

  always_comb begin
    enablesOk = !enPrimN && enSecond && !enThirdN;
    // processor strobe only counts while the primary enable is active
    procTaken = !procStrobeN && !enPrimN;
    ctrlTaken = !procTaken && !ctrlStrobeN;
    deselect  = (procTaken || ctrlTaken) && !enablesOk;

    strobe.load = (procTaken || ctrlTaken) && enablesOk;
    strobe.adv  = !procTaken && !ctrlTaken && selected && !advN;
    strobe.rd   = (procTaken && enablesOk)
               || (ctrlTaken && enablesOk && wrEnN)
               || (strobe.adv && wrEnN);
    strobe.wr   = (ctrlTaken && enablesOk && !wrEnN)
               || (strobe.adv && !wrEnN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            selected <= 1'b0;
    else if (strobe.load) selected <= 1'b1;
    else if (deselect)    selected <= 1'b0;
  end

endmodule

// File: rtl/sbf_datapath.sv
module sbf_datapath
  import sbf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sbfStrobe_t              strobe,
  input  logic                    orderSel,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES-1:0]        byteWrN,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic [LANES*LANE_W-1:0] memRdData,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    memRd,
  output logic                    memWr,
  output logic [LANES-1:0]        memByteMask,
  output logic [LANES*LANE_W-1:0] memWrData,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);

  localparam int DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] baseAddr, nextBase, accessAddr;
  logic [BEAT_W-1:0] beat, nextBeat;
  logic [DATA_W-1:0] stageData;
  logic              stageValid;

  always_comb begin
    nextBase   = strobe.load ? addrIn : baseAddr;
    nextBeat   = strobe.load ? '0 : (strobe.adv ? beat + 1'b1 : beat);
    accessAddr = {nextBase[ADDR_W-1:BEAT_W],
                  burstLow(nextBase[BEAT_W-1:0], nextBeat, orderSel)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr  <= '0;
      beat      <= '0;
      memAddr   <= '0;
      memRd     <= 1'b0;
      memWr     <= 1'b0;
      memWrData <= '0;
    end else begin
      baseAddr <= nextBase;
      beat     <= nextBeat;
      memRd    <= strobe.rd;
      memWr    <= strobe.wr;
      if (strobe.rd || strobe.wr) memAddr <= accessAddr;
      if (strobe.wr)              memWrData <= wrData;
    end
  end

  // one mask flop per byte lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) memByteMask[g] <= 1'b0;
      else       memByteMask[g] <= strobe.wr && !byteWrN[g];
    end
  end

  // two-register read return: array capture, then output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageData  <= '0;
      stageValid <= 1'b0;
      rdData     <= '0;
      rdValid    <= 1'b0;
    end else begin
      stageData  <= memRdData;
      stageValid <= memRd;
      rdData     <= stageData;
      rdValid    <= stageValid;
    end
  end

endmodule

// File: rtl/sync_burst_front.sv
module sync_burst_front
  import sbf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    procStrobeN,
  input  logic                    ctrlStrobeN,
  input  logic                    enPrimN,
  input  logic                    enSecond,
  input  logic                    enThirdN,
  input  logic                    wrEnN,
  input  logic [LANES-1:0]        byteWrN,
  input  logic                    advN,
  input  logic                    orderSel,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic [LANES*LANE_W-1:0] memRdData,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    memRd,
  output logic                    memWr,
  output logic [LANES-1:0]        memByteMask,
  output logic [LANES*LANE_W-1:0] memWrData,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);

  sbfStrobe_t strobe;

  sbf_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN),
    .enPrimN    (enPrimN),
    .enSecond   (enSecond),
    .enThirdN   (enThirdN),
    .wrEnN      (wrEnN),
    .advN       (advN),
    .strobe     (strobe)
  );

  sbf_datapath #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .orderSel   (orderSel),
    .addrIn     (addrIn),
    .byteWrN    (byteWrN),
    .wrData     (wrData),
    .memRdData  (memRdData),
    .memAddr    (memAddr),
    .memRd      (memRd),
    .memWr      (memWr),
    .memByteMask(memByteMask),
    .memWrData  (memWrData),
    .rdData     (rdData),
    .rdValid    (rdValid)
  );

endmodule

// File: rtl/sbf_chk.sv
module sbf_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              enPrimN,
  input logic              enSecond,
  input logic              enThirdN,
  input logic              wrEnN,
  input logic              advN,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRd,
  input logic              memWr,
  input logic [LANES-1:0]  memByteMask,
  input logic              rdValid
);

  // R1
  proc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !enPrimN && enSecond && !enThirdN)
      |=> (memRd && memAddr == $past(addrIn)));

  // R2
  proc_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !enPrimN) |=> !memWr);

  // R3
  proc_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && enPrimN && ctrlStrobeN && advN)
      |=> (!memRd && !memWr && $stable(memAddr)));

  // R4
  proc_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !enPrimN && (!enSecond || enThirdN)) |=> (!memRd && !memWr));

  // R5
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && !ctrlStrobeN && !enPrimN && enSecond && !enThirdN)
      |=> (memAddr == $past(addrIn) && memWr == !$past(wrEnN) && memRd == $past(wrEnN)));

  // R6
  ctrl_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && enPrimN) |=> (!memRd && !memWr));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && ctrlStrobeN && advN) |=> (!memRd && !memWr && $stable(memAddr)));

  // R11
  mask_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWr |-> (memByteMask == '0));

  // R12
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> ##1 rdValid);

  // R12
  no_read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memRd |=> ##1 !rdValid);

endmodule

bind sync_burst_front sbf_chk #(
  .ADDR_W(ADDR_W),
  .LANES (LANES),
  .LANE_W(LANE_W)
) chk_i (.*);

// File: tb/sync_burst_front_tb.sv
`timescale 1ns/1ps
module sync_burst_front_tb_top;

  localparam int AW     = 6;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DW     = LANES * LANE_W;
  localparam int DEPTH  = 1 << AW;

  logic            clk = 1'b0;
  logic            rstN;
  logic            procStrobeN, ctrlStrobeN, enPrimN, enSecond, enThirdN;
  logic            wrEnN, advN, orderSel;
  logic [LANES-1:0] byteWrN;
  logic [AW-1:0]   addrIn;
  logic [DW-1:0]   wrData, memRdData;
  logic [AW-1:0]   memAddr;
  logic            memRd, memWr, rdValid;
  logic [LANES-1:0] memByteMask;
  logic [DW-1:0]   memWrData, rdData;

  logic [DW-1:0] mem   [DEPTH];
  logic [DW-1:0] model [DEPTH];

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  sync_burst_front #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .enPrimN(enPrimN), .enSecond(enSecond), .enThirdN(enThirdN), .wrEnN(wrEnN),
    .byteWrN(byteWrN), .advN(advN), .orderSel(orderSel), .addrIn(addrIn),
    .wrData(wrData), .memRdData(memRdData), .memAddr(memAddr), .memRd(memRd),
    .memWr(memWr), .memByteMask(memByteMask), .memWrData(memWrData),
    .rdData(rdData), .rdValid(rdValid)
  );

  // behavioural array
  assign memRdData = mem[memAddr];
  always_ff @(posedge clk) begin
    if (memWr)
      for (int j = 0; j < LANES; j++)
        if (memByteMask[j]) mem[memAddr][j*LANE_W +: LANE_W] <= memWrData[j*LANE_W +: LANE_W];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setIdle();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advN = 1'b1; wrEnN = 1'b1;
    byteWrN = '1; enPrimN = 1'b0; enSecond = 1'b1; enThirdN = 1'b0;
  endtask

  function automatic logic [AW-1:0] bAddr(input logic [AW-1:0] start, input int i, input bit ord);
    logic [1:0] lo;
    lo = ord ? (start[1:0] ^ 2'(i)) : 2'(start[1:0] + 2'(i));
    return {start[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a ^ 6'h2A, 2'b01, ~a, 2'b10};
  endfunction

  // processor read with write controls active; data checked two edges later
  task automatic procReadCheck(input logic [AW-1:0] a);
    setIdle();
    procStrobeN = 1'b0; ctrlStrobeN = 1'b0; wrEnN = 1'b0; byteWrN = '0; addrIn = a;
    tick();
    chk(memRd && !memWr && memAddr == a, "R1/R2 proc read no write", {memWr, memAddr}, {1'b0, a});
    setIdle();
    tick();
    tick();
    chk(rdValid && rdData == model[a], "R12 proc read data", rdData, model[a]);
  endtask

  task automatic runBurst(input logic [AW-1:0] start, input bit ord);
    string rq;
    rq = ord ? "R8 interleaved" : "R7 linear";
    setIdle(); orderSel = ord; tick();
    procStrobeN = 1'b0; addrIn = start;
    tick();
    procStrobeN = 1'b1;
    chk(memRd && memAddr == start, rq, memAddr, start);
    for (int t = 1; t <= 5; t++) begin
      advN = (t <= 3) ? 1'b0 : 1'b1;
      tick();
      if (t <= 3)
        chk(memRd && memAddr == bAddr(start, t, ord), {rq, " R9 beat"}, memAddr, bAddr(start, t, ord));
      if (t >= 2)
        chk(rdValid && rdData == model[bAddr(start, t - 2, ord)], "R12 burst data",
            rdData, model[bAddr(start, t - 2, ord)]);
    end
    tick();
    chk(!rdValid, "R12 valid drops", rdValid, 0);
  endtask

  initial begin
    setIdle(); orderSel = 1'b0; addrIn = '0; wrData = '0; rstN = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; model[i] = '0; end
    tick(); tick();
    chk(!memRd && !memWr && !rdValid && memByteMask == 0, "R12 reset state",
        {memRd, memWr, rdValid, memByteMask}, 0);
    rstN = 1'b1;
    tick();

    // R5/R11: controller write sweep over every address
    for (int a = 0; a < DEPTH; a++) begin
      setIdle();
      ctrlStrobeN = 1'b0; wrEnN = 1'b0; byteWrN = '0; addrIn = AW'(a); wrData = pat(AW'(a));
      tick();
      model[a] = pat(AW'(a));
      chk(memWr && !memRd && memAddr == AW'(a) && memByteMask == 2'b11 && memWrData == pat(AW'(a)),
          "R5 R11 ctrl write", {memByteMask, memAddr}, {2'b11, AW'(a)});
    end
    setIdle(); tick();

    for (int a = 0; a < DEPTH; a += 7) procReadCheck(AW'(a));

    // R7/R8 sweep: every start offset, three bases, both orders
    for (int o = 0; o < 2; o++)
      for (int b = 0; b < 3; b++)
        for (int s = 0; s < 4; s++)
          runBurst(AW'((b * 5) * 4 + s), o[0]);
    orderSel = 1'b0; setIdle(); tick();

    // R9 R11: burst writes with single-lane masks
    ctrlStrobeN = 1'b0; addrIn = 6'd14; tick();
    chk(memRd && memAddr == 6'd14, "R5 ctrl read load", memAddr, 14);
    setIdle(); advN = 1'b0; wrEnN = 1'b0; byteWrN = 2'b10; wrData = 16'hBEEF; tick();
    model[15][7:0] = 8'hEF;
    chk(memWr && memAddr == 6'd15 && memByteMask == 2'b01 && memWrData == 16'hBEEF,
        "R9 R11 lane0 burst write", {memByteMask, memAddr}, {2'b01, 6'd15});
    byteWrN = 2'b01; wrData = 16'h1234; tick();
    model[12][15:8] = 8'h12;
    chk(memWr && memAddr == 6'd12 && memByteMask == 2'b10, "R9 R11 lane1 burst write",
        {memByteMask, memAddr}, {2'b10, 6'd12});
    setIdle(); tick();
    procReadCheck(6'd15);
    procReadCheck(6'd12);

    // R10: hold then resume
    procStrobeN = 1'b0; addrIn = 6'd33; tick();
    setIdle(); advN = 1'b0; tick();
    chk(memAddr == 6'd34, "R9 advance", memAddr, 34);
    advN = 1'b1; addrIn = 6'd3; tick();
    chk(!memRd && !memWr && memAddr == 6'd34, "R10 hold", {memRd, memAddr}, 34);
    advN = 1'b0; tick();
    chk(memRd && memAddr == 6'd35, "R10 resume", memAddr, 35);

    // R3: processor strobe with primary enable high is ignored, burst continues
    setIdle(); procStrobeN = 1'b0; addrIn = 6'd40; tick();
    procStrobeN = 1'b0; enPrimN = 1'b1; advN = 1'b0; addrIn = 6'd9; tick();
    chk(memRd && memAddr == 6'd41, "R3 ignored strobe vs advance", memAddr, 41);
    advN = 1'b1; tick();
    chk(!memRd && !memWr && memAddr == 6'd41, "R3 ignored strobe no access", memAddr, 41);

    // R5: controller strobe aborts burst while advance is also asserted
    setIdle(); procStrobeN = 1'b0; addrIn = 6'd20; tick();
    setIdle(); ctrlStrobeN = 1'b0; advN = 1'b0; addrIn = 6'd50; tick();
    chk(memRd && memAddr == 6'd50, "R5 abort load", memAddr, 50);
    setIdle(); advN = 1'b0; tick();
    chk(memAddr == 6'd51, "R5 abort then advance", memAddr, 51);

    // R4: processor strobe deselects on second/third enable
    setIdle(); procStrobeN = 1'b0; enSecond = 1'b0; tick();
    chk(!memRd && !memWr, "R4 deselect second", {memRd, memWr}, 0);
    setIdle(); advN = 1'b0; tick();
    chk(!memRd && !memWr && memAddr == 6'd51, "R4 no advance after deselect", memAddr, 51);
    tick();
    chk(!rdValid, "R4 R12 valid low", rdValid, 0);
    setIdle(); procStrobeN = 1'b0; addrIn = 6'd7; tick();
    setIdle(); procStrobeN = 1'b0; enThirdN = 1'b1; tick();
    chk(!memRd && !memWr, "R4 deselect third", {memRd, memWr}, 0);

    // R6: controller strobe with primary enable high deselects
    setIdle(); procStrobeN = 1'b0; addrIn = 6'd8; tick();
    setIdle(); ctrlStrobeN = 1'b0; enPrimN = 1'b1; wrEnN = 1'b0; tick();
    chk(!memRd && !memWr, "R6 ctrl deselect", {memRd, memWr}, 0);
    setIdle(); advN = 1'b0; wrEnN = 1'b0; byteWrN = '0; tick();
    chk(!memRd && !memWr && memByteMask == 0, "R6 stays deselected", {memWr, memByteMask}, 0);
    setIdle(); tick(); tick();
    procReadCheck(6'd9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule